// File: doc/BRIEF.md
# Inter-Core Mailbox Bank

This block keeps a bank of 32-bit mailboxes that processor cores use to signal one another. Each core owns four mailboxes, so the default bank holds sixteen. A core raises bits in a mailbox by writing a one-hot or multi-bit word to that mailbox's set address. The receiver removes the bits it has handled by writing them to the matching clear address. Every mailbox drives one interrupt line that stays high while any bit of the mailbox is set. That line goes to the owning core's interrupt router, which handles enable masking and the choice between normal and fast interrupt.

The register side has several identical write ports, two by default, so that two cores can post or acknowledge in the same cycle. There is also one registered read port. The set and clear regions share one decoded layout:

- a two-bit region field at the top of the address,
- then the core number,
- then the mailbox number,
- then two byte-offset bits that are ignored.

With the default sizes, core `c` mailbox `m` has its set word at `0x80 + 16*c + 4*m` and its clear word at `0xC0 + 16*c + 4*m`.

Top module: `mbox_bank`

## Requirements
- R1: The bank holds NUM_CORES x BOX_PER_CORE mailboxes. Mailbox `m` of core `c` has flat index `s = c*BOX_PER_CORE + m`. Its interrupt is `mbox_irq[s]`. With default sizes the address fields are: bits [7:6] region, bits [5:4] core, bits [3:2] mailbox, bits [1:0] ignored.
- R2: A write to a set address (region `2'b10`) ORs the write data into the addressed mailbox. The result is visible after the clock edge that samples the write.
- R3: A write to a clear address (region `2'b11`) zeroes those bits of the addressed mailbox where the write data is 1. All other bits are left unchanged.
- R4: `mbox_irq[s]` is high exactly while mailbox `s` is nonzero. It changes after the same edge as the mailbox content.
- R5: A read with `rd_en` high at a clear address returns the mailbox content in `rd_data` after the next edge. The returned value is the content before any write sampled at that same edge. While `rd_en` is low, `rd_data` holds its value.
- R6: A read at a set address, or at any address whose bit 7 is 0, returns zero.
- R7: When sets and clears reach one mailbox in the same cycle, all sets are applied first and then all clears. Sets from several ports to one mailbox combine by OR.
- R8: Writes to addresses whose bit 7 is 0 change no mailbox.
- R9: A synchronous active-high `rst` clears every mailbox, every interrupt line and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_WPORTS | Write strobe, one per write port |
| wr_addr | input | NUM_WPORTS x ADDR_W | Byte address, one per write port |
| wr_data | input | NUM_WPORTS x DATA_W | Write data, one per write port |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Registered read data |
| mbox_irq | output | NUM_CORES x BOX_PER_CORE | Per-mailbox level interrupt |

## Verification
A write sampled at an edge shows up in the mailbox interrupt lines right after that edge. A read sampled at the same edge returns the content from before that write, one register later. The bench drives inputs on the falling edge and applies its model update at the rising edge; it queues each expected read word at that rising edge and pops it on the next falling edge. On every falling edge the monitor also compares all interrupt lines against the model. Because of this, each result is checked in the half-cycle right after the edge that produced it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLEAR = 2'd2
    } acc_kind_e;

    // Region field: 2'b10 raises bits, 2'b11 drops bits, anything else is unmapped.
    function automatic acc_kind_e region_kind(input logic en, input logic [1:0] region);
        if (!en || !region[1]) return ACC_NONE;
        return region[0] ? ACC_CLEAR : ACC_SET;
    endfunction

endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
    import mbox_pkg::*;
#(
    parameter int unsigned SLOT_W = 4,
    parameter int unsigned ADDR_W = SLOT_W + 4
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);
    assign kind = region_kind(en, addr[ADDR_W-1:ADDR_W-2]);
    assign slot = addr[SLOT_W+1:2];
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_WPORTS = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_WPORTS-1:0][DATA_W-1:0] set_mask,
    input  logic [NUM_WPORTS-1:0][DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0]                 content,
    output logic                              active
);
    logic [DATA_W-1:0] set_any;
    logic [DATA_W-1:0] clr_any;

    always_comb begin
        set_any = '0;
        clr_any = '0;
        for (int p = 0; p < NUM_WPORTS; p++) begin
            set_any = set_any | set_mask[p];
            clr_any = clr_any | clr_mask[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) content <= '0;
        else     content <= (content | set_any) & ~clr_any;
    end

    assign active = |content;

    assert_set_visible_R2: assert property (@(posedge clk) disable iff (rst)
        (|set_any) && !(|clr_any) |=> ((content & $past(set_any)) == $past(set_any)));

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (|clr_any) |=> ((content & $past(clr_any)) == '0));

    assert_clear_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        !(|set_any) && (|clr_any) |=> ((content & ~$past(clr_any)) == ($past(content) & ~$past(clr_any))));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(|set_any) && !(|clr_any) |=> $stable(content));

endmodule

// File: rtl/mbox_read_port.sv
module mbox_read_port
    import mbox_pkg::*;
#(
    parameter int unsigned TOTAL  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOT_W = 4,
    parameter int unsigned ADDR_W = SLOT_W + 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [TOTAL-1:0][DATA_W-1:0] contents,
    output logic [DATA_W-1:0]            rd_data
);
    acc_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] pick;

    mbox_addr_dec #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_rdec (
        .en(rd_en), .addr(rd_addr), .kind(kind), .slot(slot)
    );

    always_comb begin
        pick = '0;
        if (kind == ACC_CLEAR) pick = contents[slot];
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= pick;
    end

    assert_set_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rd_en && (kind != ACC_CLEAR) |=> (rd_data == '0));

    assert_read_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_CORES    = 4,
    parameter int unsigned BOX_PER_CORE = 4,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned NUM_WPORTS   = 2,
    localparam int unsigned CORE_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int unsigned BOX_W       = (BOX_PER_CORE > 1) ? $clog2(BOX_PER_CORE) : 1,
    localparam int unsigned SLOT_W      = CORE_W + BOX_W,
    localparam int unsigned TOTAL       = NUM_CORES * BOX_PER_CORE,
    localparam int unsigned ADDR_W      = SLOT_W + 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_WPORTS-1:0]             wr_en,
    input  logic [NUM_WPORTS-1:0][ADDR_W-1:0] wr_addr,
    input  logic [NUM_WPORTS-1:0][DATA_W-1:0] wr_data,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [TOTAL-1:0]                  mbox_irq
);
    acc_kind_e                         wkind [NUM_WPORTS];
    logic [SLOT_W-1:0]                 wslot [NUM_WPORTS];
    logic [NUM_WPORTS-1:0][DATA_W-1:0] set_m [TOTAL];
    logic [NUM_WPORTS-1:0][DATA_W-1:0] clr_m [TOTAL];
    logic [TOTAL-1:0][DATA_W-1:0]      contents;

    for (genvar p = 0; p < NUM_WPORTS; p++) begin : g_wdec
        mbox_addr_dec #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_wdec (
            .en(wr_en[p]), .addr(wr_addr[p]), .kind(wkind[p]), .slot(wslot[p])
        );
    end

    for (genvar s = 0; s < TOTAL; s++) begin : g_box
        always_comb begin
            for (int p = 0; p < NUM_WPORTS; p++) begin
                set_m[s][p] = '0;
                clr_m[s][p] = '0;
                if (wslot[p] == SLOT_W'(s)) begin
                    if (wkind[p] == ACC_SET)   set_m[s][p] = wr_data[p];
                    if (wkind[p] == ACC_CLEAR) clr_m[s][p] = wr_data[p];
                end
            end
        end

        mbox_cell #(.DATA_W(DATA_W), .NUM_WPORTS(NUM_WPORTS)) u_cell (
            .clk(clk), .rst(rst),
            .set_mask(set_m[s]), .clr_mask(clr_m[s]),
            .content(contents[s]), .active(mbox_irq[s])
        );
    end

    mbox_read_port #(.TOTAL(TOTAL), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .contents(contents), .rd_data(rd_data)
    );

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (mbox_irq == '0) && (rd_data == '0));

endmodule

// File: tb/mbox_bank_test.sv
`timescale 1ns/1ps
module mbox_bank_test;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       wr_en = '0;
    logic [1:0][7:0]  wr_addr = '0;
    logic [1:0][31:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic [15:0]      mbox_irq;

    int compared = 0;
    int mismatched = 0;
    bit live = 0;
    logic [31:0] model [16];

    typedef struct { logic [31:0] exp; string req; } rd_item_t;
    rd_item_t rd_q[$];
    string irq_req = "R4";

    always #2 clk = ~clk;

    mbox_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .mbox_irq(mbox_irq)
    );

    function automatic void check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] v;
        for (int s = 0; s < 16; s++) v[s] = (model[s] != 0);
        return v;
    endfunction

    // Monitor: pops queued read results and compares interrupt lines on each falling edge.
    always @(negedge clk) begin
        if (live) begin
            check({irq_req, " irq"}, {16'h0, mbox_irq}, {16'h0, exp_irq()});
            while (rd_q.size() > 0) begin
                rd_item_t it;
                it = rd_q.pop_front();
                check({it.req, " rd_data"}, rd_data, it.exp);
            end
        end
    end

    // Driver: called at a falling edge, one clock of stimulus.
    task automatic cyc(input bit e0, input logic [7:0] a0, input logic [31:0] d0,
                       input bit e1, input logic [7:0] a1, input logic [31:0] d1,
                       input bit re, input logic [7:0] ra, input string req);
        logic [31:0] setv [16];
        logic [31:0] clrv [16];
        wr_en = {e1, e0}; wr_addr = {a1, a0}; wr_data = {d1, d0};
        rd_en = re; rd_addr = ra; irq_req = req;
        @(posedge clk);
        if (re) rd_q.push_back('{(ra[7:6] == 2'b11) ? model[ra[5:2]] : 32'h0, req});
        for (int s = 0; s < 16; s++) begin setv[s] = 0; clrv[s] = 0; end
        if (e0 && a0[7]) begin if (a0[6]) clrv[a0[5:2]] |= d0; else setv[a0[5:2]] |= d0; end
        if (e1 && a1[7]) begin if (a1[6]) clrv[a1[5:2]] |= d1; else setv[a1[5:2]] |= d1; end
        for (int s = 0; s < 16; s++) model[s] = (model[s] | setv[s]) & ~clrv[s];
        @(negedge clk);
        wr_en = '0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        cyc(1, a, d, 0, 8'h0, 32'h0, 0, 8'h0, req);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        cyc(0, 8'h0, 32'h0, 0, 8'h0, 32'h0, 1, a, req);
    endtask

    initial begin
        #(200000 * 4);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++) model[s] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1;
        // R9: everything reads back zero out of reset
        check("R9 rd_data", rd_data, 32'h0);
        for (int s = 0; s < 16; s++) rd(8'hC0 + 8'(4 * s), "R9");

        // R2 / R4 / R5: set then OR more bits
        wr(8'h80, 32'h0000_0001, "R2");
        rd(8'hC0, "R5");
        wr(8'h80, 32'h0000_00F0, "R2");
        rd(8'hC0, "R2");
        // R3: partial clear, then full clear drops the line
        wr(8'hC0, 32'h0000_0001, "R3");
        rd(8'hC0, "R3");
        wr(8'hC0, 32'h0000_00F0, "R4");
        rd(8'hC0, "R4");

        // R1: core 2 mailbox 3 -> flat index 11, address 0xAC / 0xEC
        wr(8'hAC, 32'hDEAD_BEEF, "R1");
        rd(8'hEC, "R1");
        wr(8'hB4, 32'h8000_0000, "R1");   // core 3 mailbox 1 -> index 13
        rd(8'hF4, "R1");
        // R1: byte-offset bits ignored
        wr(8'h85, 32'h0000_0100, "R1");
        rd(8'hC4, "R1");

        // R6: set addresses and unmapped addresses read zero
        rd(8'hAC, "R6");
        rd(8'h40, "R6");
        rd(8'h2C, "R6");

        // R7: set and clear on one mailbox in one cycle, both port orders
        cyc(1, 8'h88, 32'h0000_00FF, 1, 8'hC8, 32'h0000_000F, 0, 8'h0, "R7");
        rd(8'hC8, "R7");
        cyc(1, 8'hC8, 32'h0000_0F00, 1, 8'h88, 32'h0000_0F0F, 0, 8'h0, "R7");
        rd(8'hC8, "R7");
        // R7: two sets to one mailbox combine
        cyc(1, 8'h9C, 32'h0001_0000, 1, 8'h9C, 32'h0002_0000, 0, 8'h0, "R7");
        rd(8'hDC, "R7");

        // R8: writes to unmapped regions change nothing
        wr(8'h40, 32'hFFFF_FFFF, "R8");
        wr(8'h0C, 32'hFFFF_FFFF, "R8");
        wr(8'h6C, 32'hFFFF_FFFF, "R8");
        rd(8'hC0, "R8");
        rd(8'hEC, "R8");

        // R5: read sees content before a same-cycle write
        cyc(1, 8'hC0 + 8'h10, 32'h0, 0, 8'h0, 32'h0, 1, 8'hEC, "R5");
        cyc(1, 8'hEC, 32'hFFFF_FFFF, 0, 8'h0, 32'h0, 1, 8'hEC, "R5");
        // R5: rd_data holds while rd_en is low
        wr(8'hAC, 32'h0000_0001, "R5");
        check("R5 hold", rd_data, 32'hDEAD_BEEF);
        rd(8'hEC, "R5");

        // R9: reset mid-run clears all
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int s = 0; s < 16; s++) model[s] = 0;
        irq_req = "R9";
        @(negedge clk);
        rst = 1'b0;
        check("R9 rd_data", rd_data, 32'h0);
        rd(8'hF4, "R9");
        rd(8'hEC, "R9");

        @(negedge clk);
        live = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule